// File: doc/BRIEF.md
# Fast Context Switch Address Remapper

This block sits between the address output of a processor core and its memory management unit. It holds a process slot number in a register with one copy per security world. Each virtual address that falls in the lowest 32MB window is moved into the 32MB slot named by the current world's copy. Addresses at or above 32MB pass through unchanged. A slot number of zero, which is the reset value, gives an identity mapping. The address path is purely combinational, so the remapping adds no cycle.

Software reads and writes the register through a coprocessor-style access port. The port carries a register selector, a direction bit, a world flag, a privilege flag and a lock input that blocks secure writes. An illegal access raises an undefined-exception flag in the same cycle and changes nothing. Every accepted write asks for a flush of the branch target cache with a single-cycle pulse, because the cached branch targets were built under the old mapping.

Top module: `fcs_remap`

## Requirements
- R1: The register is 32 bits wide. The slot number is held in bits [31:25] and bits [24:0] always read as zero, whatever was written to them.
- R2: When va_in[31:25] is zero, mva_out equals va_in + slot * 2^25. The low bits [24:0] are kept and the slot number appears in bits [31:25].
- R3: When va_in[31:25] is non-zero, mva_out equals va_in.
- R4: After reset, both copies hold zero, so mva_out equals va_in for every address.
- R5: There are two copies of the register, secure (world_ns=0) and non-secure (world_ns=1). world_ns chooses which copy is read, written and used for translation. A write to one copy leaves the other unchanged.
- R6: An access with priv=0 raises undef_exc in its cycle, returns rd_data of zero and does not update the register.
- R7: A write with world_ns=0 and sec_wr_lock=1 raises undef_exc and does not update the register. A non-secure privileged write is not affected by sec_wr_lock.
- R8: An accepted write makes btc_flush high for exactly the one cycle after the write edge.
- R9: Reads, and writes that raise undef_exc, never produce btc_flush.
- R10: The register is selected only by acc_crn=13, acc_crm=0, acc_op1=0 and acc_op2=0. Any other selector raises no exception, returns zero data, writes nothing and gives no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_crn | input | 4 | Primary register selector |
| acc_crm | input | 4 | Secondary register selector |
| acc_op1 | input | 3 | First opcode selector |
| acc_op2 | input | 3 | Second opcode selector |
| acc_wdata | input | 32 | Write data |
| world_ns | input | 1 | Current world: 0 secure, 1 non-secure |
| priv | input | 1 | 1 = privileged mode |
| sec_wr_lock | input | 1 | Blocks secure writes when high |
| rd_data | output | 32 | Read data, valid in the cycle of a legal read |
| undef_exc | output | 1 | Undefined-exception flag for the current access |
| btc_flush | output | 1 | Branch target cache flush pulse |
| va_in | input | 32 | Virtual address from the core |
| mva_out | output | 32 | Modified virtual address to the MMU |

## Verification
The assertions assume that each access strobe lasts one cycle and that its selector, direction, world, privilege and lock inputs are stable for that cycle. They also assume that world_ns has the same meaning for translation as for access. The bench changes inputs only at the falling edge and raises acc_valid for exactly one clock per access. It sweeps all 128 slot values in both worlds over addresses on both sides of the 32MB boundary. It then covers every privilege, world and lock combination, together with selectors that differ from the chosen one in a single field.

// File: rtl/fcs_pkg.sv
// Shared constants and types for the fast context switch remapper.
// Assumes a 32-bit address space split into 2^PID_W equal slots.
package fcs_pkg;
    localparam int ADDR_W   = 32;
    localparam int PID_W    = 7;
    localparam int SLOT_LSB = ADDR_W - PID_W;

    localparam logic [3:0] SEL_CRN = 4'd13;
    localparam logic [3:0] SEL_CRM = 4'd0;
    localparam logic [2:0] SEL_OP1 = 3'd0;
    localparam logic [2:0] SEL_OP2 = 3'd0;

    localparam int N_WORLDS = 2;

    typedef enum logic {
        WORLD_SEC = 1'b0,
        WORLD_NS  = 1'b1
    } world_e;

    typedef struct packed {
        logic hit;
        logic rd_ok;
        logic wr_ok;
        logic undef;
    } acc_dec_t;
endpackage

// File: rtl/fcs_acc_dec.sv
// Access decoder: checks whether an access targets the slot register and
// whether the current mode is allowed to perform it.
// Assumes the strobe and its qualifiers are stable for the whole cycle.
module fcs_acc_dec
    import fcs_pkg::*;
(
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic [3:0] acc_crn,
    input  logic [3:0] acc_crm,
    input  logic [2:0] acc_op1,
    input  logic [2:0] acc_op2,
    input  world_e     world,
    input  logic       priv,
    input  logic       sec_wr_lock,
    output acc_dec_t   dec
);
    logic sel_match;
    logic sec_blocked;

    // Selector compare against the fixed register coordinates.
    always_comb begin
        sel_match = (acc_crn == SEL_CRN) && (acc_crm == SEL_CRM) &&
                    (acc_op1 == SEL_OP1) && (acc_op2 == SEL_OP2);
    end

    // Permission check and outcome of the access.
    always_comb begin
        sec_blocked = acc_write && (world == WORLD_SEC) && sec_wr_lock;
        dec.hit     = acc_valid && sel_match;
        dec.undef   = dec.hit && (!priv || sec_blocked);
        dec.rd_ok   = dec.hit && !acc_write && priv;
        dec.wr_ok   = dec.hit && acc_write && priv && !sec_blocked;
    end
endmodule

// File: rtl/fcs_pid_bank.sv
// Banked slot register, one copy per world, plus the flush pulse register.
// Reserved bits are masked on write, so they always hold zero.
// Assumes wr_ok is high for at most one cycle per accepted write.
module fcs_pid_bank
    import fcs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PID_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ok,
    input  world_e        world,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] cur_reg,
    output logic [PW-1:0] cur_pid,
    output logic          flush
);
    localparam int              LSB      = AW - PW;
    localparam logic [AW-1:0]   KEEP_MSK = {{PW{1'b1}}, {LSB{1'b0}}};

    logic [AW-1:0] bank_q [N_WORLDS];

    for (genvar g = 0; g < N_WORLDS; g++) begin : g_bank
        // Holds the copy of world g; only its own world may write it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[g] <= '0;
            else if (wr_ok && (int'(world) == g))
                bank_q[g] <= wdata & KEEP_MSK;
        end
    end

    // Pick the copy of the current world.
    always_comb begin
        cur_reg = (world == WORLD_NS) ? bank_q[1] : bank_q[0];
        cur_pid = cur_reg[AW-1:LSB];
    end

    // One-cycle flush request after every accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flush <= 1'b0;
        else
            flush <= wr_ok;
    end
endmodule

// File: rtl/fcs_va_xlate.sv
// Combinational relocation of the lowest slot: an address whose top PW
// bits are zero gets the slot number added to those bits. Other
// addresses pass through unchanged. The sum has no carry out of the top bit.
module fcs_va_xlate
    import fcs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PID_W
) (
    input  logic [AW-1:0] va,
    input  logic [PW-1:0] pid,
    output logic [AW-1:0] mva
);
    localparam int LSB = AW - PW;

    logic          low_slot;
    logic [PW-1:0] top_sum;

    // Slot add on the top field and pass-through selection.
    always_comb begin
        low_slot = (va[AW-1:LSB] == '0);
        top_sum  = va[AW-1:LSB] + pid;
        mva      = low_slot ? {top_sum, va[LSB-1:0]} : va;
    end
endmodule

// File: rtl/fcs_remap.sv
// Top level of the fast context switch remapper. It ties together the
// access decoder, the banked slot register and the address translator.
// Read data and the exception flag are combinational in the access cycle.
module fcs_remap
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [3:0]        acc_crn,
    input  logic [3:0]        acc_crm,
    input  logic [2:0]        acc_op1,
    input  logic [2:0]        acc_op2,
    input  logic [ADDR_W-1:0] acc_wdata,
    input  logic              world_ns,
    input  logic              priv,
    input  logic              sec_wr_lock,
    output logic [ADDR_W-1:0] rd_data,
    output logic              undef_exc,
    output logic              btc_flush,
    input  logic [ADDR_W-1:0] va_in,
    output logic [ADDR_W-1:0] mva_out
);
    world_e            world;
    acc_dec_t          dec;
    logic [ADDR_W-1:0] cur_reg;
    logic [PID_W-1:0]  cur_pid;

    // World flag to enum.
    always_comb world = world_e'(world_ns);

    fcs_acc_dec u_dec (
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_crn     (acc_crn),
        .acc_crm     (acc_crm),
        .acc_op1     (acc_op1),
        .acc_op2     (acc_op2),
        .world       (world),
        .priv        (priv),
        .sec_wr_lock (sec_wr_lock),
        .dec         (dec)
    );

    fcs_pid_bank #(.AW(ADDR_W), .PW(PID_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (dec.wr_ok),
        .world   (world),
        .wdata   (acc_wdata),
        .cur_reg (cur_reg),
        .cur_pid (cur_pid),
        .flush   (btc_flush)
    );

    fcs_va_xlate #(.AW(ADDR_W), .PW(PID_W)) u_xlate (
        .va  (va_in),
        .pid (cur_pid),
        .mva (mva_out)
    );

    // Read port and exception flag.
    always_comb begin
        rd_data   = dec.rd_ok ? cur_reg : '0;
        undef_exc = dec.undef;
    end
endmodule

// File: rtl/fcs_remap_chk.sv
// Property checker for fcs_remap, attached by bind. Assumes one-cycle
// access strobes with stable qualifiers.
module fcs_remap_chk
    import fcs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [3:0]        acc_crn,
    input logic [3:0]        acc_crm,
    input logic [2:0]        acc_op1,
    input logic [2:0]        acc_op2,
    input logic              world_ns,
    input logic              priv,
    input logic              sec_wr_lock,
    input logic [ADDR_W-1:0] rd_data,
    input logic              undef_exc,
    input logic              btc_flush,
    input logic [ADDR_W-1:0] va_in,
    input logic [ADDR_W-1:0] mva_out
);
    logic sel, good_wr;
    always_comb begin
        sel     = acc_valid && acc_crn == 4'd13 && acc_crm == 4'd0 &&
                  acc_op1 == 3'd0 && acc_op2 == 3'd0;
        good_wr = sel && acc_write && priv && !(!world_ns && sec_wr_lock);
    end

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[SLOT_LSB-1:0] == '0);
    p_low_bits_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mva_out[SLOT_LSB-1:0] == va_in[SLOT_LSB-1:0]);
    p_high_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (va_in[ADDR_W-1:SLOT_LSB] != '0) |-> (mva_out == va_in));
    p_user_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !priv) |-> (undef_exc && rd_data == '0));
    p_sec_lock_undef_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && acc_write && !world_ns && sec_wr_lock) |-> undef_exc);
    p_flush_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        good_wr |=> btc_flush);
    p_flush_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !good_wr |=> !btc_flush);
    p_no_flush_exc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        undef_exc |=> !btc_flush);
    p_other_sel_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (!undef_exc && rd_data == '0));
endmodule

bind fcs_remap fcs_remap_chk u_chk (.*);

// File: tb/sim_fcs_remap.sv
`timescale 1ns/1ps
module sim_fcs_remap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]  acc_crn = 4'd13, acc_crm = 4'd0;
    logic [2:0]  acc_op1 = 3'd0, acc_op2 = 3'd0;
    logic [31:0] acc_wdata = '0;
    logic        world_ns = 1'b0, priv = 1'b1, sec_wr_lock = 1'b0;
    logic [31:0] rd_data;
    logic        undef_exc, btc_flush;
    logic [31:0] va_in = '0;
    logic [31:0] mva_out;

    int n_chk = 0, n_bad = 0;
    logic [31:0] model [2];

    always #2.5 clk = ~clk;

    fcs_remap u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] xlate(logic [31:0] va, logic [31:0] r);
        return (va < 32'h0200_0000) ? va + (32'(r[31:25]) * 32'h0200_0000) : va;
    endfunction

    // One access; expectations are derived from the requirements.
    task automatic access(logic wr, logic ns, logic pv, logic lk,
                          logic [3:0] crn, logic [3:0] crm,
                          logic [2:0] o1, logic [2:0] o2, logic [31:0] d,
                          string req);
        logic hit, und, ok;
        hit = (crn == 4'd13) && (crm == 4'd0) && (o1 == 3'd0) && (o2 == 3'd0);
        und = hit && (!pv || (wr && !ns && lk));
        ok  = hit && !und;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; world_ns = ns; priv = pv;
        sec_wr_lock = lk; acc_crn = crn; acc_crm = crm; acc_op1 = o1;
        acc_op2 = o2; acc_wdata = d;
        #1;
        check({req, " undef"}, 32'(undef_exc), 32'(und));
        if (!wr) check({req, " rdata"}, rd_data, ok ? model[ns] : 32'h0);
        @(posedge clk); #1;
        acc_valid = 1'b0;
        check({req, " flush"}, 32'(btc_flush), 32'(wr && ok));
        if (wr && ok) model[ns] = d & 32'hFE00_0000;
        @(posedge clk); #1;
        check({req, " flush one cycle R8"}, 32'(btc_flush), 32'h0);
    endtask

    task automatic mva_chk(logic ns, logic [31:0] va, string req);
        @(negedge clk);
        world_ns = ns; va_in = va;
        #1;
        check(req, mva_out, xlate(va, model[ns]));
    endtask

    task automatic rd(logic ns, string req);
        access(1'b0, ns, 1'b1, 1'b0, 4'd13, 4'd0, 3'd0, 3'd0, 32'h0, req);
    endtask

    task automatic wr(logic ns, logic [31:0] d, string req);
        access(1'b1, ns, 1'b1, 1'b0, 4'd13, 4'd0, 3'd0, 3'd0, d, req);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        model[0] = '0; model[1] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R4: reset state
        check("R4 flush at reset", 32'(btc_flush), 32'h0);
        rd(1'b0, "R4 secure reset");
        rd(1'b1, "R4 nonsecure reset");
        mva_chk(1'b0, 32'h0123_4567, "R4 identity");
        mva_chk(1'b1, 32'h01FF_FFFF, "R4 identity ns");
        // R1: reserved bits masked
        wr(1'b1, 32'hFFFF_FFFF, "R1 write all ones");
        rd(1'b1, "R1 readback");
        rd(1'b0, "R5 secure copy untouched");
        // R2 R3 R5 R8: sweep every slot in both worlds
        for (int p = 0; p < 128; p++) begin
            wr(1'b0, (32'(p) << 25) | 32'h00AB_CDEF, "R8 sweep secure");
            wr(1'b1, (32'(127 - p) << 25), "R8 sweep ns");
            mva_chk(1'b0, 32'h0000_0000, "R2 base");
            mva_chk(1'b0, 32'h01FF_FFFF, "R2 top of slot");
            mva_chk(1'b1, 32'h0000_1234, "R5 ns translate");
            mva_chk(1'b0, 32'h0200_0000, "R3 boundary");
            mva_chk(1'b1, 32'hFFFF_FFFF, "R3 high");
        end
        wr(1'b0, 32'h0600_0000, "R8 set secure 3");
        wr(1'b1, 32'h0A00_0000, "R8 set ns 5");
        // R6: user mode
        access(1'b1, 1'b0, 1'b0, 1'b0, 4'd13, 4'd0, 3'd0, 3'd0, 32'hFE00_0000, "R6 user write sec");
        access(1'b1, 1'b1, 1'b0, 1'b0, 4'd13, 4'd0, 3'd0, 3'd0, 32'hFE00_0000, "R6 user write ns");
        access(1'b0, 1'b1, 1'b0, 1'b0, 4'd13, 4'd0, 3'd0, 3'd0, 32'h0, "R6 user read");
        rd(1'b0, "R6 secure unchanged");
        rd(1'b1, "R6 ns unchanged");
        // R7: secure write lock
        access(1'b1, 1'b0, 1'b1, 1'b1, 4'd13, 4'd0, 3'd0, 3'd0, 32'h1E00_0000, "R7 locked secure write");
        rd(1'b0, "R7 secure unchanged");
        mva_chk(1'b0, 32'h0000_0040, "R7 mapping unchanged");
        access(1'b1, 1'b1, 1'b1, 1'b1, 4'd13, 4'd0, 3'd0, 3'd0, 32'h2200_0000, "R7 ns write under lock");
        rd(1'b1, "R7 ns updated");
        access(1'b0, 1'b0, 1'b1, 1'b1, 4'd13, 4'd0, 3'd0, 3'd0, 32'h0, "R9 locked secure read");
        // R9: reads never flush (checked inside access)
        rd(1'b0, "R9 read no flush");
        // R10: other selectors
        access(1'b1, 1'b0, 1'b1, 1'b0, 4'd13, 4'd0, 3'd0, 3'd1, 32'hFE00_0000, "R10 op2=1");
        access(1'b1, 1'b0, 1'b1, 1'b0, 4'd12, 4'd0, 3'd0, 3'd0, 32'hFE00_0000, "R10 crn=12");
        access(1'b1, 1'b1, 1'b1, 1'b0, 4'd13, 4'd1, 3'd0, 3'd0, 32'hFE00_0000, "R10 crm=1");
        access(1'b1, 1'b1, 1'b0, 1'b0, 4'd13, 4'd0, 3'd1, 3'd0, 32'hFE00_0000, "R10 op1=1 user");
        access(1'b0, 1'b0, 1'b1, 1'b0, 4'd13, 4'd0, 3'd0, 3'd4, 32'h0, "R10 read other");
        rd(1'b0, "R10 secure unchanged");
        rd(1'b1, "R10 ns unchanged");
        mva_chk(1'b1, 32'h0100_0000, "R10 ns mapping unchanged");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule